// File: doc/BRIEF.md
# Alarm and Periodic Interrupt Controller

This block merges three interrupt causes into a single active-low request line of the open-drain kind: the pad only ever pulls the line low and otherwise lets it float, so several devices can share one wire. The causes are a time-of-day alarm, a periodic rate picked from fifteen prescaler taps, and a power-fail level coming from an analog sensor.

The timekeeping block supplies the BCD seconds, minutes and hours, a one-cycle strobe `tick` issued once the counters have advanced, and one strobe per periodic rate. The rates run from 1/128 s through 1 s, 1 min and 1 h up to 1 day, and their order is fixed by the tap index. Each cause sets a sticky status bit. A read strobe clears all of the status bits together. The request line is pulled low for as long as an enabled status bit is set. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `irqc_top`

## Requirements
- R1: After reset, `stat` is 000 and `irq_oe` is 0.
- R2: When `tick` is high and all three fields match (`cur_sec`==`alm_sec`, `cur_min`==`alm_min`, `cur_hr`==`alm_hr`), `stat[0]` (alarm) is set on the next clock edge. If any one field differs, the tick does not set it.
- R3: A full time match while `tick` is low does not set `stat[0]`.
- R4: With `per_sel` = k in 1..15, a strobe on `tap_stb[k-1]` sets `stat[1]` (periodic) on the next edge. Strobes on the other taps have no effect.
- R5: With `per_sel` = 0, no tap strobe sets `stat[1]`.
- R6: `pf_lvl` passes through a 2-stage synchronizer. Its rising edge sets `stat[2]` (power-fail) on the third clock edge after the level changes. A level that stays high does not set the bit again after a clear.
- R7: A set status bit stays set until a read.
- R8: `stat_rd` high for one cycle clears all status bits on the next edge. An event that arrives in the same cycle as the read is kept.
- R9: `irq_oe` is 1 exactly when `stat & src_en` is non-zero, where `src_en[0]`/`[1]`/`[2]` enable alarm/periodic/power-fail. Status bits are set whether or not their source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Strobe marking that the time counters have advanced |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hr | input | 8 | Current hours, BCD, including any AM/PM bit |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hr | input | 8 | Alarm hours |
| tap_stb | input | 15 | Prescaler rate strobes, index 0 fastest |
| per_sel | input | 4 | Periodic rate select, 0 = off |
| pf_lvl | input | 1 | Power-fail level, asynchronous |
| src_en | input | 3 | Per-source interrupt enables |
| stat_rd | input | 1 | Status read strobe, clears all status bits |
| stat | output | 3 | Sticky status: alarm, periodic, power-fail |
| irq_oe | output | 1 | Pull the shared interrupt line low when 1 |

## Verification
The bench uses the default parameters: 8-bit time fields, fifteen taps with a 4-bit select, and a two-stage synchronizer. These values make the whole select space small enough to cover completely. Every select code, including the disable code, is crossed with a strobe on every tap, and every one of the eight match/mismatch patterns of the three alarm fields is applied both with and without a tick. All eight enable masks are applied against several status patterns. The power-fail latency, the edge-only behaviour of the power-fail input and the event that coincides with a read are each checked at their exact cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_N = 3;
  localparam int SRC_ALARM    = 0;
  localparam int SRC_PERIODIC = 1;
  localparam int SRC_PWRFAIL  = 2;
endpackage

// File: rtl/irqc_alarm_cmp.sv
module irqc_alarm_cmp #(
  parameter int TW = 8
) (
  input  logic          tick,
  input  logic [TW-1:0] cur_sec,
  input  logic [TW-1:0] cur_min,
  input  logic [TW-1:0] cur_hr,
  input  logic [TW-1:0] alm_sec,
  input  logic [TW-1:0] alm_min,
  input  logic [TW-1:0] alm_hr,
  output logic          alarm_ev
);
  localparam int NF = 3;
  logic [TW-1:0] cur_a [NF];
  logic [TW-1:0] alm_a [NF];
  logic [NF-1:0] eq;

  assign cur_a[0] = cur_sec;
  assign cur_a[1] = cur_min;
  assign cur_a[2] = cur_hr;
  assign alm_a[0] = alm_sec;
  assign alm_a[1] = alm_min;
  assign alm_a[2] = alm_hr;

  for (genvar g = 0; g < NF; g++) begin : g_field
    assign eq[g] = (cur_a[g] == alm_a[g]);
  end

  // Compared only on the tick so one match gives one event.
  assign alarm_ev = tick & (&eq);
endmodule

// File: rtl/irqc_rate_sel.sv
module irqc_rate_sel #(
  parameter int NRATE = 15,
  parameter int SEL_W = $clog2(NRATE + 1)
) (
  input  logic [NRATE-1:0] tap_stb,
  input  logic [SEL_W-1:0] per_sel,
  output logic             per_ev
);
  always_comb begin
    per_ev = 1'b0;
    for (int k = 1; k <= NRATE; k++) begin
      if (per_sel == SEL_W'(k)) per_ev = tap_stb[k-1];
    end
  end
endmodule

// File: rtl/irqc_pf_edge.sv
module irqc_pf_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_lvl,
  output logic pf_ev
);
  logic [SYNC-1:0] sync_q;
  logic            last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pf_lvl};
      last_q <= sync_q[SYNC-1];
    end
  end

  assign pf_ev = sync_q[SYNC-1] & ~last_q;
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         rd,
  output logic [N-1:0] st
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= 1'b0;
      else        st[i] <= (rd ? 1'b0 : st[i]) | ev[i];
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int TW    = 8,
  parameter int NRATE = 15,
  parameter int SEL_W = $clog2(NRATE + 1),
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [TW-1:0]    cur_sec,
  input  logic [TW-1:0]    cur_min,
  input  logic [TW-1:0]    cur_hr,
  input  logic [TW-1:0]    alm_sec,
  input  logic [TW-1:0]    alm_min,
  input  logic [TW-1:0]    alm_hr,
  input  logic [NRATE-1:0] tap_stb,
  input  logic [SEL_W-1:0] per_sel,
  input  logic             pf_lvl,
  input  logic [SRC_N-1:0] src_en,
  input  logic             stat_rd,
  output logic [SRC_N-1:0] stat,
  output logic             irq_oe
);
  logic [SRC_N-1:0] ev;

  irqc_alarm_cmp #(.TW(TW)) u_alarm (
    .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .alarm_ev(ev[SRC_ALARM])
  );

  irqc_rate_sel #(.NRATE(NRATE), .SEL_W(SEL_W)) u_rate (
    .tap_stb(tap_stb), .per_sel(per_sel), .per_ev(ev[SRC_PERIODIC])
  );

  irqc_pf_edge #(.SYNC(SYNC)) u_pf (
    .clk(clk), .rst_n(rst_n), .pf_lvl(pf_lvl), .pf_ev(ev[SRC_PWRFAIL])
  );

  irqc_status #(.N(SRC_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .rd(stat_rd), .st(stat)
  );

  assign irq_oe = |(stat & src_en);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int TW    = 8,
  parameter int NRATE = 15,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [TW-1:0]    cur_sec,
  input logic [TW-1:0]    cur_min,
  input logic [TW-1:0]    cur_hr,
  input logic [TW-1:0]    alm_sec,
  input logic [TW-1:0]    alm_min,
  input logic [TW-1:0]    alm_hr,
  input logic [NRATE-1:0] tap_stb,
  input logic [SEL_W-1:0] per_sel,
  input logic [2:0]       src_en,
  input logic             stat_rd,
  input logic [2:0]       stat,
  input logic             irq_oe
);
  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur_sec == alm_sec && cur_min == alm_min && cur_hr == alm_hr) |=> stat[0]); // R2
  AST_ALARM_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stat[0]) |=> !stat[0]); // R3
  AST_PERIODIC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel == '0 && !stat[1]) |=> !stat[1]); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat & $past(stat)) == $past(stat))); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tick && tap_stb == '0) |=> (stat[1:0] == 2'b00)); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == 3'b000) |-> !irq_oe); // R9
  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'b000) |-> !irq_oe); // R9
endmodule

bind irqc_top irqc_chk #(.TW(TW), .NRATE(NRATE), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
  .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
  .tap_stb(tap_stb), .per_sel(per_sel), .src_en(src_en),
  .stat_rd(stat_rd), .stat(stat), .irq_oe(irq_oe)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  cur_sec = '0, cur_min = '0, cur_hr = '0;
  logic [7:0]  alm_sec = '0, alm_min = '0, alm_hr = '0;
  logic [14:0] tap_stb = '0;
  logic [3:0]  per_sel = '0;
  logic        pf_lvl = 1'b0;
  logic [2:0]  src_en = '0;
  logic        stat_rd = 1'b0;
  logic [2:0]  stat;
  logic        irq_oe;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .tap_stb(tap_stb), .per_sel(per_sel), .pf_lvl(pf_lvl),
    .src_en(src_en), .stat_rd(stat_rd), .stat(stat), .irq_oe(irq_oe)
  );

  function automatic logic [7:0] bcd(int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_stat();
    stat_rd = 1'b1;
    cyc(1);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check("R1 stat", 32'(stat), 0);
    check("R1 irq_oe", 32'(irq_oe), 0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 stat after release", 32'(stat), 0);

    // Periodic: every select code against every tap
    for (int s = 0; s < 16; s++) begin
      for (int j = 0; j < 15; j++) begin
        per_sel = 4'(s);
        clear_stat();
        tap_stb = 15'(1) << j;
        cyc(1);
        tap_stb = '0;
        check(s == 0 ? "R5 periodic off" : "R4 periodic tap",
              32'(stat[1]), 32'((s != 0) && (j == s - 1)));
        check("R9 disabled no irq", 32'(irq_oe), 0);
      end
    end
    per_sel = '0;

    // Alarm: every field-match pattern
    for (int a = 0; a < 6; a++) begin
      for (int m = 0; m < 8; m++) begin
        int ns, nm, nh;
        ns = (a * 7 + 3) % 60; nm = (a * 11 + 5) % 60; nh = (a * 5 + 1) % 24;
        clear_stat();
        alm_sec = bcd(ns); alm_min = bcd(nm); alm_hr = bcd(nh);
        cur_sec = m[0] ? bcd(ns) : bcd((ns + 1) % 60);
        cur_min = m[1] ? bcd(nm) : bcd((nm + 1) % 60);
        cur_hr  = m[2] ? bcd(nh) : bcd((nh + 1) % 24);
        cyc(1);
        check("R3 no tick", 32'(stat[0]), 0);
        tick = 1'b1;
        cyc(1);
        tick = 1'b0;
        check("R2 alarm on tick", 32'(stat[0]), 32'(m == 7));
        cyc(2);
        check("R7 sticky alarm", 32'(stat[0]), 32'(m == 7));
      end
    end
    cur_sec = 8'h59;

    // Power-fail latency and edge-only behaviour
    clear_stat();
    pf_lvl = 1'b1;
    cyc(2);
    check("R6 pf before latency", 32'(stat[2]), 0);
    cyc(1);
    check("R6 pf set", 32'(stat[2]), 1);
    clear_stat();
    cyc(3);
    check("R6 pf level no refire", 32'(stat[2]), 0);
    pf_lvl = 1'b0;
    cyc(3);

    // Read clears all; coincident event kept
    cur_sec = alm_sec; cur_min = alm_min; cur_hr = alm_hr;
    tick = 1'b1; per_sel = 4'd5; tap_stb = 15'(1) << 4; pf_lvl = 1'b1;
    cyc(1);
    tick = 1'b0; tap_stb = '0;
    cyc(2);
    check("R8 all set", 32'(stat), 32'h7);
    clear_stat();
    check("R8 read clears", 32'(stat), 0);
    pf_lvl = 1'b0;
    cyc(3);
    tick = 1'b1;
    cyc(1);
    tick = 1'b0;
    stat_rd = 1'b1; tap_stb = 15'(1) << 4;
    cyc(1);
    stat_rd = 1'b0; tap_stb = '0;
    check("R8 coincident kept", 32'(stat), 32'h2);
    cyc(1);
    check("R7 kept stays", 32'(stat), 32'h2);

    // Enable masks against status patterns
    for (int p = 0; p < 3; p++) begin
      logic [2:0] exp_st;
      clear_stat();
      if (p == 0) begin tick = 1'b1; exp_st = 3'b001; end
      else if (p == 1) begin tap_stb = 15'(1) << 4; exp_st = 3'b010; end
      else begin tick = 1'b1; tap_stb = 15'(1) << 4; pf_lvl = 1'b1; exp_st = 3'b111; end
      cyc(1);
      tick = 1'b0; tap_stb = '0;
      cyc(3);
      check("R9 status regardless of enable", 32'(stat), 32'(exp_st));
      for (int e = 0; e < 8; e++) begin
        src_en = 3'(e);
        #1;
        check("R9 irq_oe", 32'(irq_oe), 32'(|(exp_st & 3'(e))));
      end
      src_en = '0;
      pf_lvl = 1'b0;
      cyc(3);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule